// File: doc/BRIEF.md
# Idle Wake-Up Source Converter

This block sits beside a card host controller's power handshake. While the controller is parked in its idle state under a smart idle policy, it watches three card events: a card interrupt signalled by data line 1 being pulled low, a card insertion, and a card removal. When the global wake switch and the switch for that source are both on, it raises a wake-up request at once, through gates only, so the request works while the functional clock is stopped.

The source that caused the wake-up is kept in a sticky cause register until the idle state ends. On the first clock edge after idle is left, each kept cause is copied into its interrupt status bit, but only if that bit's status enable is on. The interrupt output follows the status bits. Wake enables and status enables are separate controls, and the hardware does not check that they agree. Software clears status bits by writing a one to them.

Top module: `wake_cause_conv`

## Requirements
- R1: A source raises `wake_o` only when `wake_glob_i` is 1 and that source's bit in `wake_en_i` is 1.
- R2: `wake_o` is 0 unless `idle_mode_i` selects smart idle (2'b10 or 2'b11) and `idle_i` is 1. Force idle (2'b00) and no idle (2'b01) never wake.
- R3: Source bit positions in every 3-bit vector are: bit 0 is insertion (`ins_i` high), bit 1 is removal (`rem_i` high), and bit 2 is card interrupt (`dat1_i` low).
- R4: `wake_o` rises in the same cycle as a qualifying source, with no clock edge in between.
- R5: After a qualifying source goes away, `wake_o` stays 1 until `idle_i` falls.
- R6: On the first rising edge with `idle_i` low after being idle, each captured cause sets its `stat_o` bit only if the matching `stat_en_i` bit is 1.
- R7: `irq_o` is 1 exactly when any `stat_o` bit is 1.
- R8: A 1 in `stat_clr_i` clears that `stat_o` bit at the next edge. A set caused by an idle exit on the same edge wins over the clear.
- R9: After reset, `stat_o`, `irq_o` and the captured cause are all 0.
- R10: Source activity while `idle_i` is 0 leaves `stat_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_i | input | 1 | Debounced card insertion event |
| rem_i | input | 1 | Debounced card removal event |
| dat1_i | input | 1 | Data line 1 level; low means card interrupt |
| wake_glob_i | input | 1 | Global wake enable |
| wake_en_i | input | 3 | Wake enable for each source |
| stat_en_i | input | 3 | Status enable for each source |
| idle_mode_i | input | 2 | Idle policy: 00 force, 01 none, 1x smart |
| idle_i | input | 1 | Controller is in the idle state |
| stat_clr_i | input | 3 | Write-1-to-clear strobe for status bits |
| wake_o | output | 1 | Wake-up request |
| stat_o | output | 3 | Interrupt status bits |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench sweeps every combination of idle policy, global enable, wake enables, status enables and the three source levels. Each combination goes through one idle entry, a source pulse, and one idle exit. Checking `wake_o` while the source is present and again after it is gone separates the combinational path from the captured cause. Checking `stat_o` after the exit separates the wake gating from the status gating, and so shows that the two enables are independent. Separate runs cover source activity outside idle, and a clear that arrives on the same edge as an idle-exit set.

// File: rtl/wake_cause_pkg.sv
package wake_cause_pkg;
    localparam int unsigned NSRC = 3;
    localparam int unsigned SRC_INS  = 0;
    localparam int unsigned SRC_REM  = 1;
    localparam int unsigned SRC_CIRQ = 2;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic      idle;
        src_vec_t  cause;
        src_vec_t  stat;
    } conv_state_t;
endpackage

// File: rtl/wake_src_gate.sv
module wake_src_gate
    import wake_cause_pkg::*;
(
    input  logic       ins_i,
    input  logic       rem_i,
    input  logic       dat1_i,
    input  logic       armed_i,
    input  src_vec_t   wake_en_i,
    output src_vec_t   hit_o
);
    src_vec_t raw;

    always_comb begin
        raw           = '0;
        raw[SRC_INS]  = ins_i;
        raw[SRC_REM]  = rem_i;
        raw[SRC_CIRQ] = ~dat1_i;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign hit_o[g] = armed_i & wake_en_i[g] & raw[g];
    end
endmodule

// File: rtl/wake_cause_conv.sv
module wake_cause_conv
    import wake_cause_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ins_i,
    input  logic       rem_i,
    input  logic       dat1_i,
    input  logic       wake_glob_i,
    input  logic [2:0] wake_en_i,
    input  logic [2:0] stat_en_i,
    input  logic [1:0] idle_mode_i,
    input  logic       idle_i,
    input  logic [2:0] stat_clr_i,
    output logic       wake_o,
    output logic [2:0] stat_o,
    output logic       irq_o
);
    conv_state_t st_d, st_q;
    logic        armed;
    logic        exit_idle;
    src_vec_t    hit;

    assign armed = idle_i & idle_mode_i[1] & wake_glob_i;

    wake_src_gate u_gate (
        .ins_i     (ins_i),
        .rem_i     (rem_i),
        .dat1_i    (dat1_i),
        .armed_i   (armed),
        .wake_en_i (wake_en_i),
        .hit_o     (hit)
    );

    assign exit_idle = st_q.idle & ~idle_i;

    always_comb begin
        st_d      = st_q;
        st_d.idle = idle_i;
        st_d.cause = idle_i ? (st_q.cause | hit) : '0;
        st_d.stat  = st_q.stat & ~stat_clr_i;
        if (exit_idle) begin
            st_d.stat = st_d.stat | (st_q.cause & stat_en_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_o = armed & (|(hit | st_q.cause));
    assign stat_o = st_q.stat;
    assign irq_o  = |st_q.stat;

    assert_wake_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (idle_i && idle_mode_i[1] && wake_glob_i));

    assert_wake_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && idle_mode_i[1] && wake_glob_i &&
         |(wake_en_i & {~dat1_i, rem_i, ins_i})) |-> wake_o);

    assert_set_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_o & ~$past(stat_o))) |-> ($past(st_q.idle) && !$past(idle_i)));

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i == 3'b111 && !exit_idle) |=> !irq_o);

    assert_quiet_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && !st_q.idle) |=> ((stat_o & ~$past(stat_o)) == 3'b000));
endmodule

// File: tb/sim_wake_cause_conv.sv
module sim_wake_cause_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_i = 1'b0, rem_i = 1'b0, dat1_i = 1'b1, wake_glob_i = 1'b0, idle_i = 1'b0;
    logic [2:0] wake_en_i = '0, stat_en_i = '0, stat_clr_i = '0;
    logic [1:0] idle_mode_i = '0;
    logic wake_o, irq_o;
    logic [2:0] stat_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_cause_conv u0 (
        .clk(clk), .rst_n(rst_n), .ins_i(ins_i), .rem_i(rem_i), .dat1_i(dat1_i),
        .wake_glob_i(wake_glob_i), .wake_en_i(wake_en_i), .stat_en_i(stat_en_i),
        .idle_mode_i(idle_mode_i), .idle_i(idle_i), .stat_clr_i(stat_clr_i),
        .wake_o(wake_o), .stat_o(stat_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            if (n_fail < 20) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(input logic [2:0] s);
        ins_i = s[0]; rem_i = s[1]; dat1_i = ~s[2];
    endtask

    task automatic step;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #200000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stat", {1'b0, stat_o}, 4'h0);
        chk("R9 irq", {3'b0, irq_o}, 4'h0);
        chk("R9 wake", {3'b0, wake_o}, 4'h0);

        for (int m = 0; m < 4; m++)
        for (int g = 0; g < 2; g++)
        for (int we = 0; we < 8; we++)
        for (int se = 0; se < 8; se++)
        for (int s = 0; s < 8; s++) begin
            logic [2:0] hit;
            hit = (m >= 2 && g == 1) ? (3'(s) & 3'(we)) : 3'b000;
            idle_mode_i = 2'(m); wake_glob_i = g[0];
            wake_en_i = 3'(we); stat_en_i = 3'(se);
            idle_i = 1'b1;
            step();
            set_src(3'(s));
            #1;
            chk("R1 R2 R3 R4 wake now", {3'b0, wake_o}, {3'b0, |hit});
            step();
            set_src(3'b000);
            #1;
            chk("R5 wake held", {3'b0, wake_o}, {3'b0, |hit});
            step();
            idle_i = 1'b0;
            #1;
            chk("R2 wake drop on exit", {3'b0, wake_o}, 4'h0);
            step();
            chk("R6 stat", {1'b0, stat_o}, {1'b0, hit & 3'(se)});
            chk("R7 irq", {3'b0, irq_o}, {3'b0, |(hit & 3'(se))});
            stat_clr_i = 3'b111;
            step();
            stat_clr_i = 3'b000;
            chk("R8 cleared", {1'b0, stat_o}, 4'h0);
        end

        // R10: activity outside idle changes nothing
        idle_mode_i = 2'b11; wake_glob_i = 1'b1; wake_en_i = 3'b111; stat_en_i = 3'b111;
        idle_i = 1'b0;
        for (int s = 1; s < 8; s++) begin
            set_src(3'(s));
            #1;
            chk("R10 no wake", {3'b0, wake_o}, 4'h0);
            step();
            step();
            chk("R10 stat", {1'b0, stat_o}, 4'h0);
        end
        set_src(3'b000);

        // R8: set on exit wins over clear on same edge; partial clear
        idle_i = 1'b1;
        step();
        set_src(3'b101);
        step();
        set_src(3'b000);
        idle_i = 1'b0;
        stat_clr_i = 3'b111;
        step();
        stat_clr_i = 3'b000;
        chk("R8 set wins", {1'b0, stat_o}, 4'h5);
        stat_clr_i = 3'b001;
        step();
        stat_clr_i = 3'b000;
        chk("R8 partial clear", {1'b0, stat_o}, 4'h4);
        chk("R7 irq remains", {3'b0, irq_o}, 4'h1);
        stat_clr_i = 3'b100;
        step();
        stat_clr_i = 3'b000;
        chk("R7 irq low", {3'b0, irq_o}, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule